// File: doc/BRIEF.md
# Transmit Buffer Read Controller

This block drains a circular transmit region held in a 32-bit wide on-chip SRAM and hands the data, one byte at a time, to the byte FIFO that feeds a serial shifter. Software fills the region and moves a write pointer forward. The block owns the read pointer and advances it for every byte the downstream side accepts. Both pointers carry a phase bit, so a completely full region can be told apart from an empty one.

The region is a window of the SRAM set at run time by a base and a limit byte offset. The block fetches one SRAM word, presents its bytes lowest lane first, and fetches the next word only after that. When software has made only part of a word available, the block sends just those bytes and then waits for more. Downstream backpressure stalls the block for as long as it lasts. An abort input releases such a stall by discarding the held word. The block also reports empty, full and a low-fill interrupt against a programmable threshold.

Top module: `txb_tx_reader`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `hw_rptr` is 0, `buf_empty` is 1, `buf_full` is 0, and `tx_valid` and `sram_req` are 0.
- R2: When the fetch logic is idle, abort is low and the region is not empty, `sram_req` is high for one cycle. `sram_addr` is then `cfg_base[15:2]` plus `hw_rptr[14:2]`, taken modulo the SRAM depth. The SRAM returns that word on `sram_rdata` in the next cycle.
- R3: The first byte of a fetched word becomes valid two cycles after the request. `tx_data` is `sram_rdata[8*k+7:8*k]` for lane k. The first lane is `hw_rptr[1:0]`, and the lanes then go upward one per accepted byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values for any number of cycles, unless abort is raised.
- R5: `hw_rptr` is `{phase, offset}`, with the phase in bit 15 and the byte offset from the base in bits 14:0. It advances by one on each cycle where `tx_valid` and `tx_ready` are both high, and it is unchanged otherwise. When the offset reaches the region size, it returns to 0 and the phase toggles.
- R6: After sending lane 3, or after a byte that makes the read pointer equal to `sw_wptr`, the block goes idle. A later increase of `sw_wptr` causes the same word to be fetched again, and sending resumes at the next unsent lane.
- R7: `buf_empty` is 1 when the two pointers are equal. `buf_full` is 1 when the offsets are equal and the phases differ.
- R8: The fill level is the offset difference when the phases match, and the region size minus the read offset plus the write offset when they differ. `lvl_irq` is high while the level is below `lvl_thresh`.
- R9: While `abort_req` is high, `tx_valid` and `sram_req` are 0, any fetched but unsent bytes are dropped, and `hw_rptr` does not move.
- R10: `abort_done` always reads 1.
- R11: The region size in bytes is `(cfg_limit | 3) - (cfg_base & ~3) + 1`. The low two bits of base and limit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 16 | Region start byte offset in the SRAM |
| cfg_limit | input | 16 | Region last-word byte offset in the SRAM |
| sw_wptr | input | 16 | Software write pointer {phase, offset} |
| lvl_thresh | input | 16 | Low-level interrupt threshold in bytes |
| abort_req | input | 1 | Abort pending transmit |
| sram_req | output | 1 | SRAM read request |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_rdata | input | 32 | SRAM read data, one cycle after request |
| tx_valid | output | 1 | Byte valid toward transmit FIFO |
| tx_data | output | 8 | Byte toward transmit FIFO |
| tx_ready | input | 1 | Transmit FIFO can accept a byte |
| hw_rptr | output | 16 | Hardware read pointer {phase, offset} |
| buf_empty | output | 1 | Region empty |
| buf_full | output | 1 | Region full |
| lvl_irq | output | 1 | Fill level below threshold |
| abort_done | output | 1 | Abort completion flag, tied high |

## Verification
The assertions assume that software only moves `sw_wptr` forward and never past the read pointer by more than one region. They also assume that base and limit change only while the region is empty, with the read offset inside the new size, and that abort leaves the pointers equal before it is released. The stimulus keeps to these rules: it reprograms the region only after the buffer has drained, fills it at most to full, and sets the write pointer equal to the read pointer while abort is high. Backpressure comes from a pseudo-random ready pattern, so stalls fall on every byte lane and across the wrap point.

// File: rtl/txb_pkg.sv
package txb_pkg;

    localparam int PTR_W   = 16;
    localparam int OFF_W   = PTR_W - 1;
    localparam int LVL_W   = PTR_W + 1;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WIDX_W  = PTR_W - LANE_W;

    localparam logic [PTR_W-1:0] BASE_RST  = 16'h0200;
    localparam logic [PTR_W-1:0] LIMIT_RST = 16'h03FC;

    typedef struct packed {
        logic             phase;
        logic [OFF_W-1:0] off;
    } bptr_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LOAD = 2'd1,
        FS_SEND = 2'd2
    } fetch_st_e;

    function automatic logic [LVL_W-1:0] region_bytes(
        input logic [PTR_W-1:0] base,
        input logic [PTR_W-1:0] limit
    );
        logic [LVL_W-1:0] hi;
        logic [LVL_W-1:0] lo;
        hi = {1'b0, limit} | LVL_W'(3);
        lo = {1'b0, base} & ~LVL_W'(3);
        return hi - lo + LVL_W'(1);
    endfunction

    function automatic bptr_t ptr_step(input bptr_t p, input logic [LVL_W-1:0] size_b);
        bptr_t n;
        if ({2'b00, p.off} + LVL_W'(1) == size_b) begin
            n.phase = ~p.phase;
            n.off   = '0;
        end else begin
            n.phase = p.phase;
            n.off   = p.off + OFF_W'(1);
        end
        return n;
    endfunction

    function automatic logic [LVL_W-1:0] fill_level(
        input bptr_t            w,
        input bptr_t            r,
        input logic [LVL_W-1:0] size_b
    );
        if (w.phase == r.phase)
            return {2'b00, w.off} - {2'b00, r.off};
        else
            return size_b - {2'b00, r.off} + {2'b00, w.off};
    endfunction

endpackage

// File: rtl/txb_rptr_reg.sv
module txb_rptr_reg
    import txb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [LVL_W-1:0] size_b,
    output bptr_t            rptr
);

    bptr_t rptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
        end else if (adv) begin
            rptr_q <= ptr_step(rptr_q, size_b);
        end
    end

    assign rptr = rptr_q;

endmodule

// File: rtl/txb_region_status.sv
module txb_region_status
    import txb_pkg::*;
(
    input  bptr_t            rptr,
    input  bptr_t            wptr,
    input  logic [LVL_W-1:0] size_b,
    input  logic [PTR_W-1:0] thresh,
    output logic             empty,
    output logic             full,
    output logic             low_irq
);

    logic             off_eq;
    logic             ph_eq;
    logic [LVL_W-1:0] level;

    always_comb begin
        off_eq  = (rptr.off == wptr.off);
        ph_eq   = (rptr.phase == wptr.phase);
        empty   = off_eq && ph_eq;
        full    = off_eq && !ph_eq;
        level   = fill_level(wptr, rptr, size_b);
        low_irq = (level < {1'b0, thresh});
    end

endmodule

// File: rtl/txb_fetch_ctrl.sv
module txb_fetch_ctrl
    import txb_pkg::*;
#(
    parameter int SRAM_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               empty,
    input  bptr_t              rptr,
    input  bptr_t              wptr,
    input  logic [LVL_W-1:0]   size_b,
    input  logic [WIDX_W-1:0]  base_widx,
    output logic               sram_req,
    output logic [SRAM_AW-1:0] sram_addr,
    input  logic [WORD_W-1:0]  sram_rdata,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_data,
    input  logic               tx_ready,
    output logic               adv
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    fetch_st_e          st_q;
    logic [WORD_W-1:0]  word_q;
    logic [LANE_W-1:0]  lane_q;
    logic [BYTE_W-1:0]  lane_byte [LANES];
    logic               stop_after;

    // Split the held word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sram_req   = (st_q == FS_IDLE) && !abort && !empty;
        sram_addr  = SRAM_AW'(base_widx + WIDX_W'(rptr.off[OFF_W-1:LANE_W]));
        tx_valid   = (st_q == FS_SEND) && !abort;
        tx_data    = lane_byte[lane_q];
        adv        = tx_valid && tx_ready;
        stop_after = (lane_q == LAST_LANE) || (ptr_step(rptr, size_b) == wptr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_IDLE;
            word_q <= '0;
            lane_q <= '0;
        end else if (abort) begin
            st_q   <= FS_IDLE;
        end else begin
            unique case (st_q)
                FS_IDLE: begin
                    if (sram_req) st_q <= FS_LOAD;
                end
                FS_LOAD: begin
                    word_q <= sram_rdata;
                    lane_q <= rptr.off[LANE_W-1:0];
                    st_q   <= FS_SEND;
                end
                FS_SEND: begin
                    if (tx_ready) begin
                        if (stop_after) st_q <= FS_IDLE;
                        else            lane_q <= lane_q + LANE_W'(1);
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txb_tx_reader.sv
module txb_tx_reader
    import txb_pkg::*;
#(
    parameter int SRAM_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        cfg_base,
    input  logic [15:0]        cfg_limit,
    input  logic [15:0]        sw_wptr,
    input  logic [15:0]        lvl_thresh,
    input  logic               abort_req,
    output logic               sram_req,
    output logic [SRAM_AW-1:0] sram_addr,
    input  logic [31:0]        sram_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic [15:0]        hw_rptr,
    output logic               buf_empty,
    output logic               buf_full,
    output logic               lvl_irq,
    output logic               abort_done
);

    logic [LVL_W-1:0]  size_b;
    logic [WIDX_W-1:0] base_widx;
    bptr_t             rptr;
    bptr_t             wptr;
    logic              adv;

    assign size_b     = region_bytes(cfg_base, cfg_limit);
    assign base_widx  = cfg_base[PTR_W-1:LANE_W];
    assign wptr       = bptr_t'(sw_wptr);
    assign hw_rptr    = rptr;
    assign abort_done = 1'b1;

    txb_rptr_reg u_rptr (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .size_b (size_b),
        .rptr   (rptr)
    );

    txb_region_status u_status (
        .rptr    (rptr),
        .wptr    (wptr),
        .size_b  (size_b),
        .thresh  (lvl_thresh),
        .empty   (buf_empty),
        .full    (buf_full),
        .low_irq (lvl_irq)
    );

    txb_fetch_ctrl #(.SRAM_AW(SRAM_AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort_req),
        .empty      (buf_empty),
        .rptr       (rptr),
        .wptr       (wptr),
        .size_b     (size_b),
        .base_widx  (base_widx),
        .sram_req   (sram_req),
        .sram_addr  (sram_addr),
        .sram_rdata (sram_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .adv        (adv)
    );

endmodule

// File: rtl/txb_tx_reader_chk.sv
module txb_tx_reader_chk #(
    parameter int SRAM_AW = 10
) (
    input logic               clk,
    input logic               rst,
    input logic [15:0]        lvl_thresh,
    input logic               abort_req,
    input logic               sram_req,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic               tx_valid,
    input logic [7:0]         tx_data,
    input logic               tx_ready,
    input logic [15:0]        hw_rptr,
    input logic               buf_empty,
    input logic               buf_full,
    input logic               lvl_irq
);

    assert_req_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        sram_req |-> !buf_empty);

    assert_hold_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (abort_req || (tx_valid && $stable(tx_data))));

    assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !$stable(hw_rptr));

    assert_ptr_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && tx_ready) |=> $stable(hw_rptr));

    assert_valid_has_data_R6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !buf_empty);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(buf_empty && buf_full));

    assert_zero_thresh_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (lvl_thresh == 16'd0) |-> !lvl_irq);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> (!tx_valid && !sram_req));

    logic unused_addr;
    assign unused_addr = ^sram_addr;

endmodule

bind txb_tx_reader txb_tx_reader_chk #(.SRAM_AW(SRAM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lvl_thresh (lvl_thresh),
    .abort_req  (abort_req),
    .sram_req   (sram_req),
    .sram_addr  (sram_addr),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .hw_rptr    (hw_rptr),
    .buf_empty  (buf_empty),
    .buf_full   (buf_full),
    .lvl_irq    (lvl_irq)
);

// File: tb/txb_tx_reader_tb.sv
`timescale 1ns/1ps
module txb_tx_reader_tb;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   cfg_base = 16'h0200;
    logic [15:0]   cfg_limit = 16'h03FC;
    logic [15:0]   sw_wptr = 16'h0;
    logic [15:0]   lvl_thresh = 16'h0;
    logic          abort_req = 1'b0;
    logic          sram_req;
    logic [AW-1:0] sram_addr;
    logic [31:0]   sram_rdata = 32'h0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;
    logic [15:0]   hw_rptr;
    logic          buf_empty, buf_full, lvl_irq, abort_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int          m_st = 0;
    int          m_off = 0;
    bit          m_ph = 0;
    int          m_lane = 0;
    logic [31:0] m_word = 0;

    always #5 clk = ~clk;

    txb_tx_reader #(.SRAM_AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .sw_wptr(sw_wptr), .lvl_thresh(lvl_thresh), .abort_req(abort_req),
        .sram_req(sram_req), .sram_addr(sram_addr), .sram_rdata(sram_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .hw_rptr(hw_rptr), .buf_empty(buf_empty), .buf_full(buf_full),
        .lvl_irq(lvl_irq), .abort_done(abort_done)
    );

    function automatic logic [31:0] mem_word(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h3C, b + 8'h11, ~b, b ^ 8'h5A};
    endfunction

    always @(posedge clk) if (sram_req) sram_rdata <= mem_word(int'(sram_addr));

    function automatic int size_b();
        return ((int'(cfg_limit) | 3) - (int'(cfg_base) & 'hFFFC) + 1);
    endfunction
    function automatic int w_off(); return int'(sw_wptr[14:0]); endfunction
    function automatic bit m_empty(); return (m_off == w_off()) && (m_ph == sw_wptr[15]); endfunction
    function automatic int m_level();
        if (m_ph == sw_wptr[15]) return w_off() - m_off;
        return size_b() - m_off + w_off();
    endfunction

    // model update
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_off = 0; m_ph = 0; m_lane = 0;
        end else if (abort_req) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (!m_empty()) m_st = 1;
                1: begin
                    m_word = mem_word(((int'(cfg_base) >> 2) + (m_off >> 2)) % DEPTH);
                    m_lane = m_off % 4;
                    m_st   = 2;
                end
                default: if (tx_ready) begin
                    m_off = m_off + 1;
                    if (m_off == size_b()) begin m_off = 0; m_ph = ~m_ph; end
                    if (m_lane == 3 || m_empty()) m_st = 0;
                    else m_lane = m_lane + 1;
                end
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit exp_req, exp_val;
        cyc++;
        if (cyc > 1) begin
            exp_req = (m_st == 0) && !abort_req && !m_empty() && !rst;
            exp_val = (m_st == 2) && !abort_req && !rst;
            if (rst) begin
                chk("R1 rptr", 32'(hw_rptr), 32'h0);
                chk("R1 empty", 32'(buf_empty), 32'h1);
                chk("R1 valid", 32'(tx_valid), 32'h0);
            end
            chk("R2/R9 sram_req", 32'(sram_req), 32'(exp_req));
            if (exp_req)
                chk("R2 sram_addr", 32'(sram_addr),
                    32'(((int'(cfg_base) >> 2) + (m_off >> 2)) % DEPTH));
            chk("R3/R4/R9 tx_valid", 32'(tx_valid), 32'(exp_val));
            if (exp_val) chk("R3 tx_data", 32'(tx_data), 32'(m_word[m_lane*8 +: 8]));
            chk("R5/R6 hw_rptr", 32'(hw_rptr), {16'h0, m_ph, 15'(m_off)});
            chk("R7 empty", 32'(buf_empty), 32'(m_empty()));
            chk("R7 full", 32'(buf_full),
                32'((m_off == w_off()) && (m_ph != sw_wptr[15])));
            chk("R8/R11 irq", 32'(lvl_irq), 32'(m_level() < int'(lvl_thresh)));
            chk("R10 abort_done", 32'(abort_done), 32'h1);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rnd_ready(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            tx_ready = lfsr[0] | lfsr[3];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        tx_ready = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(3);
        // R2 R3: two whole words
        sw_wptr = 16'd8;
        step(20);
        // R6: partial words, resume mid word
        sw_wptr = 16'd10; step(10);
        sw_wptr = 16'd13; step(10);
        sw_wptr = 16'd16; step(10);
        // R8: threshold against level
        lvl_thresh = 16'd20; step(3);
        tx_ready = 1'b0;
        sw_wptr = 16'd46; step(6);
        // R4: random backpressure
        rnd_ready(150);
        step(10);
        // R11: small region, low bits of base and limit ignored
        cfg_base = 16'h0202; cfg_limit = 16'h023D; step(3);
        // R7: fill to full (phase differs, same offset), then drain across wrap
        tx_ready = 1'b0;
        sw_wptr = {1'b1, 15'd46}; step(8);
        rnd_ready(300);
        step(10);
        // R9: abort a stalled transmit
        tx_ready = 1'b0;
        sw_wptr = {1'b1, 15'd52}; step(6);
        abort_req = 1'b1; step(3);
        sw_wptr = {1'b1, 15'd46}; step(2);
        abort_req = 1'b0; step(5);
        tx_ready = 1'b1;
        sw_wptr = {1'b1, 15'd50}; step(15);
        lvl_thresh = 16'd0; step(3);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule